// File: doc/BRIEF.md
# Tagged Descriptor Access Checker

This block sits between a processor's address path and main memory on a machine in which every memory reference goes through a tagged descriptor word. Each access presents three things: the descriptor word, an index into the block that the descriptor names, and a read/write flag. A descriptor may be direct or may be a copy. A copy points, through a 20-bit reference, at an entry in a small master descriptor table held inside the block. The checker resolves a copy through its master entry. It then tests the tag, the presence bit, the bounds and the write permission. The result is either a physical address or one fault code.

When a block is absent, the checker separates two cases. An empty address field means the block has never been allocated, so it is a first-touch allocation. A nonzero address field means the block was rolled out to disk, and that field is then returned as the disk location. The block counts each of these two presence-fault kinds in its own saturating counter, so that the operating system can spot thrashing. Software loads the master table through a simple write port.

Descriptor layout, within the 48 data bits below the tag:
- bit 47: present
- bit 46: copy
- bit 45: writable
- bits 44:30: size
- bits 29:0: address (a copy uses its low 20 bits as the master reference)

The tag sits in the top `TAG_W` bits. The descriptor tag value is 5.

Top module: `desc_guard`

## Requirements
- R1: A word whose tag is not 5 raises fault code 1 (tag) and gives physical address 0.
- R2: A present, in-bounds access with permission gives fault code 0 and physical address = address field + index, truncated to 30 bits.
- R3: A descriptor that is absent and has a zero address field raises fault code 2 (allocation) with physical address 0.
- R4: A descriptor that is absent and has a nonzero address field raises fault code 3 (rollout) and returns the address field on the physical address output.
- R5: An index greater than or equal to the size field raises fault code 4 (bounds) with physical address 0.
- R6: A write to a descriptor whose writable bit is clear raises fault code 5. A read of the same descriptor is not affected.
- R7: When several faults apply, only one is reported, in this order: tag, then presence, then bounds, then write.
- R8: A copy descriptor (bit 46 set) is resolved through the master entry it names. That master entry must carry tag 5 and a clear copy bit. A reference at or beyond the table depth is treated as an untagged word. Either condition raises fault code 1.
- R9: Each allocation fault adds one to the allocation counter, and each rollout fault adds one to the rollout counter.
- R10: The counters saturate at all ones instead of wrapping.
- R11: A synchronous clear sets both counters to zero. The clear wins over an increment in the same cycle.
- R12: After reset, no response is valid and both counters read zero.
- R13: Each response appears exactly one clock after its request, and a response is marked valid only for a cycle that carried a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_word | input | TAG_W+48 | Tagged descriptor word |
| req_index | input | IDX_W | Index within the block |
| req_write | input | 1 | 1 = write access |
| mt_we | input | 1 | Master table write enable |
| mt_idx | input | IDX_W | Master table entry to write |
| mt_wdata | input | TAG_W+48 | Master table write data |
| cnt_clr | input | 1 | Clear both fault counters |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 3 | 0 ok, 1 tag, 2 allocation, 3 rollout, 4 bounds, 5 write |
| rsp_paddr | output | 30 | Physical address or disk location |
| cnt_alloc | output | CNT_W | Allocation fault count |
| cnt_roll | output | CNT_W | Rollout fault count |

## Verification
The bench exercises direct descriptors that separate each fault class on its own. Indices one below and exactly at the size show where bounds start. Reads and writes to the same read-only descriptor show that permission applies only to writes. Combined faults, such as a bad tag on an absent block or an out-of-bounds write, show that only the higher-priority fault is reported. Copy descriptors are aimed at valid, absent, chained and out-of-range master entries, which tells proper resolution apart from simply reading the copy word itself. A long run of allocation faults, followed by a clear that coincides with a fault, shows both saturation and the order of clear against increment.

// File: rtl/desc_guard.sv
module desc_guard #(
  parameter int TAG_W    = 3,
  parameter int IDX_W    = 20,
  parameter int MT_DEPTH = 16,
  parameter int CNT_W    = 32,
  parameter int PA_W     = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [TAG_W+47:0]   req_word,
  input  logic [IDX_W-1:0]    req_index,
  input  logic                req_write,
  input  logic                mt_we,
  input  logic [IDX_W-1:0]    mt_idx,
  input  logic [TAG_W+47:0]   mt_wdata,
  input  logic                cnt_clr,
  output logic                rsp_valid,
  output logic [2:0]          rsp_fault,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic [CNT_W-1:0]    cnt_alloc,
  output logic [CNT_W-1:0]    cnt_roll
);
  localparam int WORD_W = TAG_W + 48;
  localparam int SIZE_W = 15;
  localparam int MT_AW  = (MT_DEPTH > 1) ? $clog2(MT_DEPTH) : 1;
  localparam logic [TAG_W-1:0] DESC_TAG = TAG_W'(5);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [WORD_W-1:0] mt_mem [MT_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MT_DEPTH; i++) mt_mem[i] <= '0;
    end else if (mt_we && (mt_idx < IDX_W'(MT_DEPTH))) begin
      mt_mem[mt_idx[MT_AW-1:0]] <= mt_wdata;
    end
  end

  logic              is_copy, ref_ok, tag_bad, pres, wable, oob;
  logic [IDX_W-1:0]  mref;
  logic [WORD_W-1:0] mword, eff;
  logic [SIZE_W-1:0] size_f;
  logic [29:0]       addr_f;
  logic [2:0]        fault_n;
  logic [PA_W-1:0]   paddr_n;

  assign is_copy = req_word[46];
  assign mref    = req_word[IDX_W-1:0];
  assign ref_ok  = mref < IDX_W'(MT_DEPTH);
  assign mword   = ref_ok ? mt_mem[mref[MT_AW-1:0]] : '0;
  assign eff     = is_copy ? mword : req_word;

  assign tag_bad = (req_word[WORD_W-1:48] != DESC_TAG) ||
                   (is_copy && ((mword[WORD_W-1:48] != DESC_TAG) || mword[46]));
  assign pres    = eff[47];
  assign wable   = eff[45];
  assign size_f  = eff[44:30];
  assign addr_f  = eff[29:0];
  assign oob     = req_index >= IDX_W'(size_f);

  always_comb begin
    fault_n = 3'd0;
    paddr_n = '0;
    if (tag_bad)                 fault_n = 3'd1;
    else if (!pres && addr_f == '0) fault_n = 3'd2;
    else if (!pres) begin
      fault_n = 3'd3;
      paddr_n = PA_W'(addr_f);
    end
    else if (oob)                fault_n = 3'd4;
    else if (req_write && !wable) fault_n = 3'd5;
    else                         paddr_n = PA_W'(addr_f) + PA_W'(req_index);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? fault_n : 3'd0;
      rsp_paddr <= req_valid ? paddr_n : '0;
    end
  end

  wire hit_alloc = req_valid && fault_n == 3'd2;
  wire hit_roll  = req_valid && fault_n == 3'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_alloc <= '0;
      cnt_roll  <= '0;
    end else if (cnt_clr) begin
      cnt_alloc <= '0;
      cnt_roll  <= '0;
    end else begin
      if (hit_alloc && cnt_alloc != CNT_MAX) cnt_alloc <= cnt_alloc + 1'b1;
      if (hit_roll  && cnt_roll  != CNT_MAX) cnt_roll  <= cnt_roll + 1'b1;
    end
  end
endmodule

module desc_guard_chk #(
  parameter int CNT_W = 32,
  parameter int PA_W  = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             cnt_clr,
  input logic             rsp_valid,
  input logic [2:0]       rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [CNT_W-1:0] cnt_alloc,
  input logic [CNT_W-1:0] cnt_roll
);
  // R13
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));
  // R7
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault <= 3'd5);
  // R3
  alloc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'd2) |-> rsp_paddr == '0);
  // R4
  roll_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 3'd3) |-> rsp_paddr != '0);
  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_alloc == '0 && cnt_roll == '0));
  // R10
  alloc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_clr) |-> cnt_alloc >= $past(cnt_alloc));
  // R9
  alloc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_clr) && !(rsp_valid && rsp_fault == 3'd2)) |-> $stable(cnt_alloc));
  // R9
  roll_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_clr) && !(rsp_valid && rsp_fault == 3'd3)) |-> $stable(cnt_roll));
endmodule

bind desc_guard desc_guard_chk #(.CNT_W(CNT_W), .PA_W(PA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cnt_clr(cnt_clr),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
  .cnt_alloc(cnt_alloc), .cnt_roll(cnt_roll));

// File: tb/desc_guard_tb_top.sv
`timescale 1ns/1ps
module desc_guard_tb_top;
  localparam int CW = 4;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, mt_we = 0, cnt_clr = 0;
  logic [50:0] req_word = '0, mt_wdata = '0;
  logic [19:0] req_index = '0, mt_idx = '0;
  logic rsp_valid;
  logic [2:0] rsp_fault;
  logic [29:0] rsp_paddr;
  logic [CW-1:0] cnt_alloc, cnt_roll;

  int checks = 0, fails = 0;
  logic [50:0] mm [16];
  int m_alloc = 0, m_roll = 0;

  always #10 clk = ~clk;

  desc_guard #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .req_index(req_index), .req_write(req_write), .mt_we(mt_we), .mt_idx(mt_idx),
    .mt_wdata(mt_wdata), .cnt_clr(cnt_clr), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .cnt_alloc(cnt_alloc),
    .cnt_roll(cnt_roll));

  function automatic logic [50:0] mk(int tag, bit p, bit c, bit w, int size, longint addr);
    return {3'(tag), p, c, w, 15'(size), 30'(addr)};
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [50:0] w, input int idx, input bit wr,
                       output int f, output longint pa);
    logic [50:0] e;
    bit bad;
    bad = (w[50:48] != 3'd5);
    e = w;
    if (w[46]) begin
      if (w[19:0] < 16) e = mm[w[3:0]]; else e = '0;
      if (e[50:48] != 3'd5 || e[46]) bad = 1;
    end
    pa = 0;
    if (bad) f = 1;
    else if (!e[47] && e[29:0] == 0) f = 2;
    else if (!e[47]) begin f = 3; pa = e[29:0]; end
    else if (idx >= e[44:30]) f = 4;
    else if (wr && !e[45]) f = 5;
    else begin f = 0; pa = (longint'(e[29:0]) + idx) & 30'h3FFFFFFF; end
  endtask

  task automatic step(string req, bit v, logic [50:0] w, int idx, bit wr,
                      bit clr = 0, bit we = 0, int widx = 0, logic [50:0] wd = '0);
    int f; longint pa;
    @(negedge clk);
    req_valid = v; req_word = w; req_index = 20'(idx); req_write = wr;
    cnt_clr = clr; mt_we = we; mt_idx = 20'(widx); mt_wdata = wd;
    model(w, idx, wr, f, pa);
    if (!v) begin f = 0; pa = 0; end
    if (clr) begin m_alloc = 0; m_roll = 0; end
    else begin
      if (v && f == 2 && m_alloc < 15) m_alloc++;
      if (v && f == 3 && m_roll < 15) m_roll++;
    end
    @(posedge clk); #1;
    if (we && widx < 16) mm[widx] = wd;
    chk({req, " R13 valid"}, rsp_valid, v);
    chk({req, " fault"}, rsp_fault, f);
    chk({req, " paddr"}, rsp_paddr, pa);
    chk({req, " R9 alloc count"}, cnt_alloc, m_alloc);
    chk({req, " R9 roll count"}, cnt_roll, m_roll);
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mm[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 valid", rsp_valid, 0);
    chk("R12 alloc", cnt_alloc, 0);
    chk("R12 roll", cnt_roll, 0);
    @(negedge clk); rst_n = 1;

    step("R2 read", 1, mk(5,1,0,1,100,'h1000), 5, 0);
    step("R2 last", 1, mk(5,1,0,0,100,'h1000), 99, 0);
    step("R2 wrap", 1, mk(5,1,0,1,50,'h3FFFFFF0), 32, 1);
    step("R5 at size", 1, mk(5,1,0,1,100,'h1000), 100, 0);
    step("R5 far", 1, mk(5,1,0,1,100,'h1000), 'hFFFFF, 0);
    step("R1 code tag", 1, mk(3,1,0,1,100,'h1000), 1, 0);
    step("R1 zero tag", 1, mk(0,1,0,1,100,'h1000), 1, 0);
    step("R3 first touch", 1, mk(5,0,0,1,100,0), 1, 0);
    step("R4 rolled out", 1, mk(5,0,0,1,100,'h2ABCD), 1, 1);
    step("R6 ro write", 1, mk(5,1,0,0,100,'h400), 3, 1);
    step("R6 ro read", 1, mk(5,1,0,0,100,'h400), 3, 0);
    step("R7 tag over presence", 1, mk(7,0,0,0,10,0), 50, 1);
    step("R7 presence over bounds", 1, mk(5,0,0,0,10,'h77), 50, 1);
    step("R7 bounds over write", 1, mk(5,1,0,0,10,'h77), 50, 1);
    step("R13 idle", 0, mk(5,0,0,0,10,0), 0, 0);

    step("R8 load0", 0, '0, 0, 0, 0, 1, 2, mk(5,1,0,1,64,'h8000));
    step("R8 load1", 0, '0, 0, 0, 0, 1, 3, mk(5,0,0,1,64,0));
    step("R8 load2", 0, '0, 0, 0, 0, 1, 4, mk(5,1,1,1,64,'h9000));
    step("R8 load3", 0, '0, 0, 0, 0, 1, 5, mk(5,0,0,1,64,'h5555));
    step("R8 copy ok", 1, mk(5,0,1,0,0,2), 10, 1);
    step("R8 copy oob", 1, mk(5,0,1,0,0,2), 64, 0);
    step("R8 copy alloc", 1, mk(5,0,1,0,0,3), 1, 0);
    step("R8 copy roll", 1, mk(5,0,1,0,0,5), 1, 0);
    step("R8 copy chain", 1, mk(5,0,1,0,0,4), 1, 0);
    step("R8 copy far ref", 1, mk(5,0,1,0,0,'h12345), 1, 0);
    step("R8 copy empty", 1, mk(5,0,1,0,0,9), 1, 0);
    step("R8 copy bad tag word", 1, mk(4,0,1,0,0,2), 1, 0);

    for (int i = 0; i < 20; i++) step("R10 saturate", 1, mk(5,0,0,1,8,0), 0, 0);
    step("R11 clear", 0, '0, 0, 0, 1);
    step("R11 clear wins", 1, mk(5,0,0,1,8,0), 0, 0, 1);
    step("R9 after clear", 1, mk(5,0,0,1,8,'h10), 0, 0);
    step("R9 after clear alloc", 1, mk(5,0,0,1,8,0), 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule